// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects an internal word-wide request port to a parallel asynchronous memory bus of the kind used by static RAM, NOR flash and simple FPGA register files. A request carries a 32-bit word address, write data, four byte enables and a direction. The block holds the request until it completes. It then returns a one-cycle `req_ready` pulse and, for reads, the assembled word. The upper address bits pick one of several chip-select regions. Each region has a 64 MB window by default.

Every region has its own timing word. It holds separate read and write counts for the setup, strobe and hold phases, a turnaround count and a data width of 8 or 16 bits. It also holds two mode bits. One narrows the chip select to the strobe phase only. The other lets a per-region wait input stretch the strobe.

A 32-bit request is split into two halfword beats or four byte beats, and these run back to back. Timing words are written through a small configuration port.

Top module: `amc_top`

## Requirements
- R1: The top two bits of `req_waddr` select the region; only that region's bit of `mem_cs_n` is ever driven low during the access, all others stay high.
- R2: With the select-for-whole-cycle mode, each beat shows setup, strobe and hold phases lasting exactly the programmed count of clock cycles, a programmed 0 acting as 1. Reads use the read counts and writes the write counts. With no turnaround, the first select cycle is the cycle after the request is first seen while idle.
- R3: A region whose width bit is 1 runs two beats at byte addresses base+0 and base+2, low halfword first. A region whose width bit is 0 runs four beats at base+0..base+3, carrying data on bits 7:0. After reset every region is 8 bits wide with all counts 0.
- R4: Before an access, the block inserts a gap of the new region's turnaround count of idle cycles. It does so only when there was an earlier access and either the region or the direction differs from it. A count of 0 inserts nothing.
- R5: In select-strobe mode (bit 32), the region's chip select is low only in strobe cycles. Setup and hold still elapse with the select high.
- R6: In extended-wait mode (bit 33), the region's `mem_wait` bit is passed through two flops. A strobe ends in the first cycle in which its count has expired and the synchronized wait is low. If the wait falls after D strobe cycles, the strobe therefore lasts max(count, D+2) cycles. With the mode off, the wait input has no effect.
- R7: For reads, `req_rdata` holds the bytes read, lowest address in bits 7:0. The data of each beat is captured in the strobe's last cycle. `req_ready` is high for exactly one cycle, the one after the last hold cycle.
- R8: On writes, `mem_dq_oe` is high through setup, strobe and hold and `mem_we_n` is low only in strobe. `mem_be_n` is active low per byte lane: bit 0 covers bits 7:0 and bit 1 covers bits 15:8. An 8-bit region uses only bit 0. Bytes whose enable is 0 are not written.
- R9: `mem_oe_n` is low only in read strobes and `mem_we_n` only in write strobes, never both at once. A strobe only occurs while a chip select is low. After reset all strobes and selects are high.
- R10: The timing word written by `cfg_we` into region `cfg_sel` is laid out as follows:
  - read setup [3:0], read strobe [9:4], read hold [13:10]
  - write setup [17:14], write strobe [23:18], write hold [27:24]
  - turnaround [30:28]
  - 16-bit width [31], select-strobe [32], extended-wait [33]

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load timing word |
| cfg_sel | input | 2 | Region receiving the timing word |
| cfg_data | input | 34 | Timing word (layout in R10) |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 write, 0 read |
| req_waddr | input | 26 | Word address: region in top 2 bits |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables of the word |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read word, valid with ready |
| mem_addr | output | 26 | Byte address inside the region window |
| mem_dq_o | output | 16 | Bus write data |
| mem_dq_oe | output | 1 | Bus data drive enable |
| mem_dq_i | input | 16 | Bus read data |
| mem_be_n | output | 2 | Active-low byte lane enables |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_wait | input | 4 | Per-region wait, active high |

## Verification
Two events can land in the same cycle: the strobe count expiring and the synchronized wait falling. The bench provokes this by releasing the wait after a number of strobe cycles chosen so that D+2 equals the programmed strobe count. It then checks that the strobe lasts exactly that count, neither one cycle more nor less, and repeats the access with release points before and after the expiry. The second collision is a change of region and a change of direction on the same request. The bench checks that this costs exactly one gap of the new region's turnaround count, and that back-to-back same-direction accesses to the same region cost none.

// File: rtl/amc_pkg.sv
package amc_pkg;

   localparam int REQ_DW = 32;
   localparam int BUS_DW = 16;
   localparam int CNT_W  = 6;

   typedef struct packed {
      logic       ext_wait;
      logic       sel_strobe;
      logic       wide;
      logic [2:0] turn;
      logic [3:0] wr_hold;
      logic [5:0] wr_strobe;
      logic [3:0] wr_setup;
      logic [3:0] rd_hold;
      logic [5:0] rd_strobe;
      logic [3:0] rd_setup;
   } cs_cfg_t;

   localparam int CFG_W = $bits(cs_cfg_t);

   typedef enum logic [2:0] {
      ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE
   } phase_e;

   // count reload value: a width of 0 behaves as 1
   function automatic logic [CNT_W-1:0] reload(input logic [CNT_W-1:0] w);
      return (w == '0) ? '0 : w - 1'b1;
   endfunction

endpackage

// File: rtl/amc_cfg_bank.sv
module amc_cfg_bank
   import amc_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int CS_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [CS_W-1:0] cfg_sel,
   input  logic [CFG_W-1:0] cfg_data,
   output cs_cfg_t         cfg_o [NUM_CS]
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_region
      cs_cfg_t word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (cfg_we && (cfg_sel == CS_W'(i)))
            word_q <= cs_cfg_t'(cfg_data);
      end
      assign cfg_o[i] = word_q;
   end

endmodule

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("amc_wait_sync needs at least two stages");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sh <= '0;
         else
            sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end

endmodule

// File: rtl/amc_seq.sv
module amc_seq
   import amc_pkg::*;
#(
   parameter int NUM_CS  = 4,
   parameter int CS_W    = 2,
   parameter int WIN_W   = 26,
   parameter int WADDR_W = 26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  cs_cfg_t            cfg [NUM_CS],
   input  logic [NUM_CS-1:0]  wait_s,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [WADDR_W-1:0] req_waddr,
   input  logic [REQ_DW-1:0]  req_wdata,
   input  logic [3:0]         req_be,
   output logic               req_ready,
   output logic [REQ_DW-1:0]  req_rdata,
   output logic [WIN_W-1:0]   mem_addr,
   output logic [BUS_DW-1:0]  mem_dq_o,
   output logic               mem_dq_oe,
   input  logic [BUS_DW-1:0]  mem_dq_i,
   output logic [1:0]         mem_be_n,
   output logic [NUM_CS-1:0]  mem_cs_n,
   output logic               mem_oe_n,
   output logic               mem_we_n
);

   phase_e             st;
   logic [CNT_W-1:0]   cnt;
   logic [1:0]         beat;
   logic [CS_W-1:0]    cs_q, last_cs;
   logic               we_q, last_we, have_last;
   logic [WIN_W-3:0]   word_q;
   logic [REQ_DW-1:0]  wd_q, rd_q;
   logic [3:0]         be_q;

   logic [CS_W-1:0]    req_cs;
   cs_cfg_t            cur, nxt;
   logic [CNT_W-1:0]   setup_w, strobe_w, hold_w, nxt_setup;
   logic               last_beat, need_turn, stretch, active, cs_on;
   logic [1:0]         off;

   assign req_cs    = req_waddr[WADDR_W-1 -: CS_W];
   assign cur       = cfg[cs_q];
   assign nxt       = cfg[req_cs];
   assign setup_w   = CNT_W'(we_q ? cur.wr_setup : cur.rd_setup);
   assign strobe_w  = we_q ? cur.wr_strobe : cur.rd_strobe;
   assign hold_w    = CNT_W'(we_q ? cur.wr_hold : cur.rd_hold);
   assign nxt_setup = CNT_W'(req_write ? nxt.wr_setup : nxt.rd_setup);
   assign last_beat = cur.wide ? (beat == 2'd1) : (beat == 2'd3);
   assign need_turn = have_last && ((req_cs != last_cs) || (req_write != last_we))
                      && (nxt.turn != 3'd0);
   assign stretch   = cur.ext_wait && wait_s[cs_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         beat      <= '0;
         cs_q      <= '0;
         last_cs   <= '0;
         we_q      <= 1'b0;
         last_we   <= 1'b0;
         have_last <= 1'b0;
         word_q    <= '0;
         wd_q      <= '0;
         rd_q      <= '0;
         be_q      <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               cs_q   <= req_cs;
               we_q   <= req_write;
               word_q <= req_waddr[WIN_W-3:0];
               wd_q   <= req_wdata;
               be_q   <= req_be;
               beat   <= '0;
               if (need_turn) begin
                  st  <= ST_TURN;
                  cnt <= CNT_W'(nxt.turn) - 1'b1;
               end else begin
                  st  <= ST_SETUP;
                  cnt <= reload(nxt_setup);
               end
            end
            ST_TURN: if (cnt == '0) begin
               st  <= ST_SETUP;
               cnt <= reload(setup_w);
            end else cnt <= cnt - 1'b1;
            ST_SETUP: if (cnt == '0) begin
               st  <= ST_STROBE;
               cnt <= reload(strobe_w);
            end else cnt <= cnt - 1'b1;
            ST_STROBE: if (cnt != '0) cnt <= cnt - 1'b1;
            else if (!stretch) begin
               st  <= ST_HOLD;
               cnt <= reload(hold_w);
               if (!we_q) begin
                  if (cur.wide) rd_q[{beat[0], 4'b0} +: 16] <= mem_dq_i;
                  else          rd_q[{beat, 3'b0} +: 8]     <= mem_dq_i[7:0];
               end
            end
            ST_HOLD: if (cnt != '0) cnt <= cnt - 1'b1;
            else if (last_beat) begin
               st        <= ST_DONE;
               last_cs   <= cs_q;
               last_we   <= we_q;
               have_last <= 1'b1;
            end else begin
               beat <= beat + 2'd1;
               st   <= ST_SETUP;
               cnt  <= reload(setup_w);
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign active    = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
   assign cs_on     = cur.sel_strobe ? (st == ST_STROBE) : active;
   assign off       = cur.wide ? {beat[0], 1'b0} : beat;

   assign mem_cs_n  = ~(cs_on ? (NUM_CS'(1) << cs_q) : NUM_CS'(0));
   assign mem_oe_n  = !((st == ST_STROBE) && !we_q);
   assign mem_we_n  = !((st == ST_STROBE) && we_q);
   assign mem_dq_oe = active && we_q;
   assign mem_addr  = {word_q, off};
   assign mem_dq_o  = cur.wide ? wd_q[{beat[0], 4'b0} +: 16] : {8'h00, wd_q[{beat, 3'b0} +: 8]};
   assign mem_be_n  = cur.wide ? ~be_q[{beat[0], 1'b0} +: 2] : {1'b1, ~be_q[beat]};
   assign req_ready = (st == ST_DONE);
   assign req_rdata = rd_q;

endmodule

// File: rtl/amc_top.sv
module amc_top
   import amc_pkg::*;
#(
   parameter  int NUM_CS      = 4,
   parameter  int WIN_W       = 26,
   parameter  int SYNC_STAGES = 2,
   localparam int CS_W        = $clog2(NUM_CS),
   localparam int WADDR_W     = CS_W + WIN_W - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CS_W-1:0]    cfg_sel,
   input  logic [CFG_W-1:0]   cfg_data,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [WADDR_W-1:0] req_waddr,
   input  logic [REQ_DW-1:0]  req_wdata,
   input  logic [3:0]         req_be,
   output logic               req_ready,
   output logic [REQ_DW-1:0]  req_rdata,
   output logic [WIN_W-1:0]   mem_addr,
   output logic [BUS_DW-1:0]  mem_dq_o,
   output logic               mem_dq_oe,
   input  logic [BUS_DW-1:0]  mem_dq_i,
   output logic [1:0]         mem_be_n,
   output logic [NUM_CS-1:0]  mem_cs_n,
   output logic               mem_oe_n,
   output logic               mem_we_n,
   input  logic [NUM_CS-1:0]  mem_wait
);

   if (NUM_CS < 2 || NUM_CS > 16) begin : g_bad_cs
      $error("amc_top: NUM_CS must lie in 2..16");
   end
   if (WIN_W < 3) begin : g_bad_win
      $error("amc_top: WIN_W must be at least 3");
   end

   cs_cfg_t           cfg [NUM_CS];
   logic [NUM_CS-1:0] wait_s;

   amc_cfg_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .cfg_o(cfg)
   );

   amc_wait_sync #(.N(NUM_CS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(mem_wait), .q(wait_s)
   );

   amc_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_W(WIN_W), .WADDR_W(WADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .wait_s(wait_s),
      .req_valid(req_valid), .req_write(req_write), .req_waddr(req_waddr),
      .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
      .req_rdata(req_rdata), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_be_n(mem_be_n),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
   );

endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
   parameter int NUM_CS = 4,
   parameter int WIN_W  = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic [WIN_W-1:0]  mem_addr,
   input logic              mem_dq_oe,
   input logic [NUM_CS-1:0] mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n
);

   a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   a_r9_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |-> (~mem_cs_n != '0));

   a_r8_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   a_r7_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ((&mem_cs_n) && mem_oe_n && mem_we_n && !mem_dq_oe));

   a_r2_addr_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

endmodule

bind amc_top amc_chk #(.NUM_CS(NUM_CS), .WIN_W(WIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
   .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
   .mem_we_n(mem_we_n)
);

// File: tb/sim_amc_top.sv
module sim_amc_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [33:0] cfg_data = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [25:0] req_waddr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        req_ready;
   logic [31:0] req_rdata;
   logic [25:0] mem_addr;
   logic [15:0] mem_dq_o, mem_dq_i;
   logic        mem_dq_oe, mem_oe_n, mem_we_n;
   logic [1:0]  mem_be_n;
   logic [3:0]  mem_cs_n;
   logic [3:0]  mem_wait = '0;

   always #2 clk = ~clk;

   amc_top u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .req_valid(req_valid), .req_write(req_write), .req_waddr(req_waddr),
      .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .req_rdata(req_rdata),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
      .mem_be_n(mem_be_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_wait(mem_wait)
   );

   int nchk = 0, nfail = 0, cyc = 0;
   logic [7:0] devmem [4][128];
   logic [7:0] expmem [4][128];
   int rs[4], rp[4], rh[4], ws[4], wp[4], wh[4], tn[4], wide[4], ss[4], ew[4];
   bit have_last = 0; int last_c = 0; bit last_w = 0;

   // bus-side device model
   always_comb begin
      int ci;
      ci = 0;
      for (int k = 0; k < 4; k++) if (!mem_cs_n[k]) ci = k;
      mem_dq_i = {devmem[ci][mem_addr[6:0] + 7'd1], devmem[ci][mem_addr[6:0]]};
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         nchk++; nfail++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         summary();
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int eff(input int x);
      return (x == 0) ? 1 : x;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic set_cfg(input int c, input int a_rs, input int a_rp, input int a_rh,
                          input int a_ws, input int a_wp, input int a_wh, input int a_tn,
                          input int a_wd, input int a_ss, input int a_ew);
      rs[c] = a_rs; rp[c] = a_rp; rh[c] = a_rh; ws[c] = a_ws; wp[c] = a_wp; wh[c] = a_wh;
      tn[c] = a_tn; wide[c] = a_wd; ss[c] = a_ss; ew[c] = a_ew;
      cfg_data = 34'(a_rs) | (34'(a_rp) << 4) | (34'(a_rh) << 10) | (34'(a_ws) << 14)
               | (34'(a_wp) << 18) | (34'(a_wh) << 24) | (34'(a_tn) << 28)
               | (34'(a_wd) << 31) | (34'(a_ss) << 32) | (34'(a_ew) << 33);
      cfg_sel = 2'(c);
      cfg_we  = 1'b1;
      @(negedge clk);
      cfg_we  = 1'b0;
   endtask

   task automatic access(input int c, input bit w, input int word, input logic [31:0] wd,
                         input logic [3:0] be, input int drop);
      int S, P, H, T, nb, lead, total, first, got, nbt, ph, idx, a0, p0;
      int bad_cs, bad_addr, bad8, bad9;
      int su[4], sb[4], ho[4];
      logic [25:0] cur_a;
      logic [31:0] rd, ex;
      bit cs_any, strobe;
      S = eff(w ? ws[c] : rs[c]); P = eff(w ? wp[c] : rp[c]); H = eff(w ? wh[c] : rh[c]);
      T = (have_last && (c != last_c || w != last_w)) ? tn[c] : 0;
      nb = wide[c] ? 2 : 4; a0 = word * 4;
      p0 = (ew[c] != 0 && drop > 0) ? imax(P, drop + 2) : P;
      lead = (ss[c] != 0) ? T + S + 1 : T + 1;
      total = T + nb * (S + P + H) + (p0 - P) + 1;
      for (int k = 0; k < 4; k++) begin su[k] = 0; sb[k] = 0; ho[k] = 0; end
      first = -1; got = -1; nbt = 0; ph = 0; idx = 0; cur_a = '0; rd = '0;
      bad_cs = 0; bad_addr = 0; bad8 = 0; bad9 = 0;
      req_valid = 1'b1; req_write = w; req_waddr = 26'((c << 24) | word);
      req_wdata = wd; req_be = be;
      for (int i = 1; i <= 1000; i++) begin
         @(negedge clk);
         cs_any = (mem_cs_n != 4'hF);
         strobe = !mem_oe_n || !mem_we_n;
         if (!mem_oe_n && w) bad9++;
         if (!mem_we_n && !w) bad9++;
         if (strobe && !cs_any) bad9++;
         if (cs_any) begin
            if (mem_cs_n != ~(4'b1 << c)) bad_cs++;
            if (first < 0) first = i;
            if (nbt == 0 || mem_addr != cur_a) begin
               nbt++; cur_a = mem_addr; ph = 0;
               idx = (nbt > 4) ? 3 : nbt - 1;
               if (nbt > 4 || mem_addr != 26'(a0 + (wide[c] != 0 ? 2 * (nbt - 1) : nbt - 1)))
                  bad_addr++;
            end
            if (strobe) begin sb[idx]++; ph = 1; end
            else if (ph == 0) su[idx]++;
            else ho[idx]++;
            if (w && !mem_dq_oe) bad8++;
         end
         if (!mem_we_n) begin
            if (!mem_be_n[0]) devmem[c][mem_addr[6:0]] = mem_dq_o[7:0];
            if (!mem_be_n[1]) devmem[c][mem_addr[6:0] + 7'd1] = mem_dq_o[15:8];
         end
         if (drop > 0 && nbt == 1 && strobe && sb[0] == drop) mem_wait[c] = 1'b0;
         if (req_ready) begin got = i; rd = req_rdata; break; end
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk(bad_cs == 0 && first > 0, "R1 region select", bad_cs, 0);
      chk(nbt == nb && bad_addr == 0, "R3 beat count/address", nbt, nb);
      chk(first == lead, (T > 0) ? "R4 turnaround lead" : "R2 first select", first, lead);
      for (int k = 0; k < nb && k < 4; k++) begin
         if (ss[c] != 0) begin
            chk(su[k] == 0 && ho[k] == 0, "R5 select only in strobe", su[k] + ho[k], 0);
            chk(sb[k] == ((k == 0) ? p0 : P), "R5 strobe width", sb[k], (k == 0) ? p0 : P);
         end else begin
            chk(su[k] == S, "R2 setup", su[k], S);
            chk(sb[k] == ((k == 0) ? p0 : P), (p0 != P) ? "R6 stretched strobe" : "R2 strobe",
                sb[k], (k == 0) ? p0 : P);
            chk(ho[k] == H, "R2 hold", ho[k], H);
         end
      end
      chk(got == total, "R7 ready cycle", got, total);
      chk(bad9 == 0, "R9 strobe rules", bad9, 0);
      if (w) begin
         for (int k = 0; k < 4; k++) if (be[k]) expmem[c][a0 + k] = wd[8*k +: 8];
         chk(bad8 == 0, "R8 data drive", bad8, 0);
         for (int k = 0; k < 4; k++)
            chk(devmem[c][a0 + k] == expmem[c][a0 + k], "R8 byte written",
                devmem[c][a0 + k], expmem[c][a0 + k]);
      end else begin
         ex = {expmem[c][a0 + 3], expmem[c][a0 + 2], expmem[c][a0 + 1], expmem[c][a0]};
         chk(rd == ex, "R7 read data", rd, ex);
      end
      have_last = 1; last_c = c; last_w = w;
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int c = 0; c < 4; c++) begin
         rs[c] = 0; rp[c] = 0; rh[c] = 0; ws[c] = 0; wp[c] = 0; wh[c] = 0;
         tn[c] = 0; wide[c] = 0; ss[c] = 0; ew[c] = 0;
         for (int a = 0; a < 128; a++) begin
            devmem[c][a] = 8'(c * 64 + a * 7 + 3);
            expmem[c][a] = 8'(c * 64 + a * 7 + 3);
         end
      end
      repeat (3) @(negedge clk);
      chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && !req_ready && !mem_dq_oe,
          "R9 reset state", {mem_cs_n, mem_oe_n, mem_we_n}, 6'h3F);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 default: 8-bit, all widths behave as one cycle
      access(0, 0, 1, 32'h0, 4'hF, 0);
      // R10 program each region
      set_cfg(0, 2, 3, 1, 1, 4, 2, 2, 1, 0, 0);
      set_cfg(1, 0, 5, 3, 3, 2, 0, 3, 0, 1, 0);
      set_cfg(2, 1, 4, 1, 2, 3, 1, 0, 1, 0, 1);
      set_cfg(3, 3, 2, 2, 1, 1, 1, 1, 0, 0, 0);
      access(0, 1, 2, 32'hA1B2C3D4, 4'hF, 0);   // R4 direction change
      access(0, 0, 2, 32'h0, 4'h0, 0);          // R4 direction change back
      access(0, 0, 2, 32'h0, 4'h0, 0);          // R4 same region and direction: no gap
      access(1, 1, 3, 32'h11223344, 4'b0101, 0); // R5 R8 partial write
      access(1, 0, 3, 32'h0, 4'h0, 0);
      mem_wait[2] = 1'b1; repeat (3) @(negedge clk);
      access(2, 0, 0, 32'h0, 4'h0, 2);          // R6 release coincides with expiry
      mem_wait[2] = 1'b1; repeat (3) @(negedge clk);
      access(2, 0, 1, 32'h0, 4'h0, 6);          // R6 release after expiry
      mem_wait[2] = 1'b1; repeat (3) @(negedge clk);
      access(2, 0, 0, 32'h0, 4'h0, 1);          // R6 release before expiry
      mem_wait[2] = 1'b1; repeat (3) @(negedge clk);
      access(2, 1, 5, 32'hCAFEF00D, 4'b1110, 3); // R6 write stretch
      mem_wait[3] = 1'b1; repeat (3) @(negedge clk);
      access(3, 1, 6, 32'h5A6B7C8D, 4'hF, 0);   // R6 wait ignored without mode
      mem_wait[3] = 1'b0;
      for (int n = 0; n < 60; n++) begin
         if (n % 8 == 0) begin
            int c;
            c = int'($urandom % 4);
            set_cfg(c, int'($urandom % 16), int'($urandom % 64), int'($urandom % 16),
                    int'($urandom % 16), int'($urandom % 64), int'($urandom % 16),
                    int'($urandom % 8), int'($urandom % 2), int'($urandom % 2), 0);
         end
         access(int'($urandom % 4), bit'($urandom % 2), int'($urandom % 16),
                $urandom, 4'($urandom), 0);
      end
      summary();
   end

endmodule